// File: doc/BRIEF.md
# I2C Target Responder with Coded Event Reporting

This block is the target side of an I2C link. It filters the bus through synchronizers. It recognises START and STOP. It acknowledges its own 7-bit address, and it acknowledges the general call address when that address is written. It then moves bytes in either direction.

Every byte event goes to a local host as a 4-bit event code together with a one-cycle strobe. The first data byte after each addressed START gets its own code. This lets the host tell one transaction from the next. While an event waits for service, the responder holds SCL low. The host services a transmit request by loading the byte to send, and services a receive or general-call event with an acknowledge pulse.

The host can also abandon the transfer at any moment with a stop command. The responder then lets go of both lines and ignores all bus activity until a fresh START appears.

Top module: `i2c_coded_slave`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe` and `irq_strobe` are all low.
- R2: An address byte whose upper seven bits equal `own_addr` is acknowledged: SDA is pulled low during the ninth clock. An address byte with bit 0 = 0 (write) raises no event.
- R3: An address byte that matches neither `own_addr` nor the general call value 0x00 is not acknowledged. No event is raised, and every later byte is ignored until the next START.
- R4: The address byte 0x00 is acknowledged and raises code 0xF. SCL is held low until `rx_ack` is pulsed.
- R5: Each received data byte appears on `rx_data` and raises code 0xC if it is the first data byte since the addressed START, and 0xE otherwise. SCL is held low until `rx_ack`, after which the byte is acknowledged.
- R6: After a read address (bit 0 = 1) is acknowledged, code 0xB requests the first byte. After each master ACK, code 0xD requests the next byte. SCL is held low until `tx_wr` loads `tx_data`, and that byte is shifted out MSB first.
- R7: A master NACK after a transmitted byte ends the data phase. SDA stays released and no event is raised until the next START.
- R8: A repeated START with a matching address re-arms the first-byte codes (0xB / 0xC).
- R9: A `host_stop` pulse releases SCL and SDA on the next cycle. The bus is then ignored (no ACK, no event) until a new START, after which addressing works again.
- R10: When `host_stop` and `tx_wr` arrive in the same cycle, the stop wins and the loaded byte is never driven.
- R11: `irq_strobe` is high for exactly one clock per event, with a code in the range 0xB to 0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line level as seen on the bus |
| sda_in | input | 1 | SDA line level as seen on the bus |
| scl_oe | output | 1 | High pulls SCL low (clock stretch) |
| sda_oe | output | 1 | High pulls SDA low (ACK or zero data bit) |
| own_addr | input | ADDR_W | This target's 7-bit address |
| tx_data | input | DATA_W | Byte the host offers for transmission |
| tx_wr | input | 1 | Pulse: `tx_data` is valid, service a transmit request |
| rx_ack | input | 1 | Pulse: host has serviced a receive or general-call event |
| host_stop | input | 1 | Pulse: abandon the transfer and go inactive until START |
| irq_strobe | output | 1 | One-cycle event pulse |
| irq_code | output | 4 | Event code: 0xB/0xD transmit request (first/later), 0xC/0xE byte received (first/later), 0xF general call |
| rx_data | output | DATA_W | Last received data byte |

## Verification
The host stop command and the host's transmit-data write can reach the responder in the same clock while it stretches SCL for the first byte of a read. The bench provokes this by asserting `host_stop` and `tx_wr` together on one edge while the request for code 0xB is pending, with an all-zero byte on `tx_data`. The outcome is judged at the ports. Both lines must be released. The master must then clock in 0xFF rather than 0x00, which shows the loaded byte was never driven, and no further event may be raised.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK
    } phase_e;

    localparam logic [3:0] EV_TX_FIRST = 4'hB;
    localparam logic [3:0] EV_RX_FIRST = 4'hC;
    localparam logic [3:0] EV_TX_NEXT  = 4'hD;
    localparam logic [3:0] EV_RX_NEXT  = 4'hE;
    localparam logic [3:0] EV_GCALL    = 4'hF;

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.scl_pipe = {sync_q.scl_pipe[STAGES-2:0], scl_in};
        sync_d.sda_pipe = {sync_q.sda_pipe[STAGES-2:0], sda_in};
        sync_d.scl_prev = sync_q.scl_pipe[STAGES-1];
        sync_d.sda_prev = sync_q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;   // idle bus level is high
        else        sync_q <= sync_d;
    end

    assign scl_lvl   = sync_q.scl_pipe[STAGES-1];
    assign sda_lvl   = sync_q.sda_pipe[STAGES-1];
    assign scl_rise  = scl_lvl & ~sync_q.scl_prev;
    assign scl_fall  = ~scl_lvl & sync_q.scl_prev;
    // SDA edges while SCL stays high mark START and STOP
    assign start_det = scl_lvl & sync_q.scl_prev & ~sda_lvl & sync_q.sda_prev;
    assign stop_det  = scl_lvl & sync_q.scl_prev & sda_lvl & ~sync_q.sda_prev;

endmodule

// File: rtl/i2cs_addr_decode.sv
module i2cs_addr_decode #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W:0]   frame,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              own_hit,
    output logic              gcall_hit,
    output logic              rd_req
);

    assign own_hit   = (frame[ADDR_W:1] == own_addr);
    assign gcall_hit = (frame == '0);
    assign rd_req    = frame[0];

endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm
    import i2cs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              own_hit,
    input  logic              gcall_hit,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_wr,
    input  logic              rx_ack,
    input  logic              host_stop,
    output logic [DATA_W-1:0] frame,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              irq_strobe,
    output logic [3:0]        irq_code,
    output logic [DATA_W-1:0] rx_data
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] BITS_LAST = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] TX_LAST   = CNT_W'(DATA_W - 1);

    typedef struct packed {
        phase_e            phase;
        logic [DATA_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              first;
        logic              rd;
        logic              stretch;
        logic              sda_low;
        logic              strobe;
        logic [3:0]        code;
        logic [DATA_W-1:0] rxbuf;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (host_stop) begin
            st_d.phase   = PH_IDLE;
            st_d.stretch = 1'b0;
            st_d.sda_low = 1'b0;
        end else if (start_det) begin
            st_d.phase   = PH_ADDR;
            st_d.cnt     = '0;
            st_d.stretch = 1'b0;
            st_d.sda_low = 1'b0;
        end else if (stop_det) begin
            st_d.phase   = PH_IDLE;
            st_d.stretch = 1'b0;
            st_d.sda_low = 1'b0;
        end else begin
            unique case (st_q.phase)
                PH_ADDR: begin
                    if (scl_rise) begin
                        st_d.shreg = {st_q.shreg[DATA_W-2:0], sda_lvl};
                        st_d.cnt   = st_q.cnt + 1'b1;
                    end else if (scl_fall && st_q.cnt == BITS_LAST) begin
                        if (own_hit || gcall_hit) begin
                            st_d.phase   = PH_ADDR_ACK;
                            st_d.sda_low = 1'b1;
                            st_d.first   = 1'b1;
                            st_d.rd      = rd_req && !gcall_hit;
                            st_d.cnt     = '0;
                            if (gcall_hit) begin
                                st_d.stretch = 1'b1;
                                st_d.strobe  = 1'b1;
                                st_d.code    = EV_GCALL;
                            end
                        end else begin
                            st_d.phase = PH_IDLE;
                        end
                    end
                end
                PH_ADDR_ACK: begin
                    if (st_q.stretch) begin
                        if (rx_ack) st_d.stretch = 1'b0;
                    end else if (scl_fall) begin
                        st_d.sda_low = 1'b0;
                        st_d.cnt     = '0;
                        if (st_q.rd) begin
                            st_d.phase   = PH_TX;
                            st_d.strobe  = 1'b1;
                            st_d.code    = st_q.first ? EV_TX_FIRST : EV_TX_NEXT;
                            st_d.first   = 1'b0;
                            st_d.stretch = 1'b1;
                        end else begin
                            st_d.phase = PH_RX;
                        end
                    end
                end
                PH_RX: begin
                    if (scl_rise) begin
                        st_d.shreg = {st_q.shreg[DATA_W-2:0], sda_lvl};
                        st_d.cnt   = st_q.cnt + 1'b1;
                    end else if (scl_fall && st_q.cnt == BITS_LAST) begin
                        st_d.rxbuf   = st_q.shreg;
                        st_d.strobe  = 1'b1;
                        st_d.code    = st_q.first ? EV_RX_FIRST : EV_RX_NEXT;
                        st_d.first   = 1'b0;
                        st_d.stretch = 1'b1;
                        st_d.phase   = PH_RX_ACK;
                    end
                end
                PH_RX_ACK: begin
                    if (st_q.stretch) begin
                        if (rx_ack) begin
                            st_d.stretch = 1'b0;
                            st_d.sda_low = 1'b1;
                        end
                    end else if (scl_fall) begin
                        st_d.sda_low = 1'b0;
                        st_d.cnt     = '0;
                        st_d.phase   = PH_RX;
                    end
                end
                PH_TX: begin
                    if (st_q.stretch) begin
                        if (tx_wr) begin
                            st_d.shreg   = tx_data;
                            st_d.sda_low = ~tx_data[DATA_W-1];
                            st_d.stretch = 1'b0;
                            st_d.cnt     = '0;
                        end
                    end else if (scl_fall) begin
                        if (st_q.cnt == TX_LAST) begin
                            st_d.sda_low = 1'b0;
                            st_d.phase   = PH_TX_ACK;
                        end else begin
                            st_d.shreg   = {st_q.shreg[DATA_W-2:0], 1'b0};
                            st_d.sda_low = ~st_q.shreg[DATA_W-2];
                            st_d.cnt     = st_q.cnt + 1'b1;
                        end
                    end
                end
                PH_TX_ACK: begin
                    if (scl_rise && sda_lvl) begin
                        st_d.phase = PH_IDLE;
                    end else if (scl_fall) begin
                        st_d.phase   = PH_TX;
                        st_d.strobe  = 1'b1;
                        st_d.code    = st_q.first ? EV_TX_FIRST : EV_TX_NEXT;
                        st_d.first   = 1'b0;
                        st_d.stretch = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame      = st_q.shreg;
    assign scl_oe     = st_q.stretch;
    assign sda_oe     = st_q.sda_low;
    assign irq_strobe = st_q.strobe;
    assign irq_code   = st_q.code;
    assign rx_data    = st_q.rxbuf;

    // R9: the stop command frees both lines one cycle later
    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_stop |=> (!scl_oe && !sda_oe));

    // R11: an event strobe never lasts two cycles
    p_strobe_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_strobe |=> !irq_strobe);

    // R11: every reported code lies in the defined range
    p_code_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_strobe |-> (irq_code >= 4'hB));

    // R5: a stretch persists until the host services it (or the bus restarts)
    p_hold_until_served_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && !tx_wr && !rx_ack && !host_stop && !start_det) |=> scl_oe);

    // R6: data and ACK drive only move while SCL is low, except on a forced reset of the bus
    p_sda_moves_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |->
        (!$past(scl_lvl) || $past(host_stop) || $past(start_det) || $past(stop_det)));

endmodule

// File: rtl/i2c_coded_slave.sv
module i2c_coded_slave #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_wr,
    input  logic              rx_ack,
    input  logic              host_stop,
    output logic              irq_strobe,
    output logic [3:0]        irq_code,
    output logic [DATA_W-1:0] rx_data
);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic own_hit, gcall_hit, rd_req;
    logic [DATA_W-1:0] frame;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cs_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .frame     (frame[ADDR_W:0]),
        .own_addr  (own_addr),
        .own_hit   (own_hit),
        .gcall_hit (gcall_hit),
        .rd_req    (rd_req)
    );

    i2cs_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_lvl    (scl_lvl),
        .sda_lvl    (sda_lvl),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .own_hit    (own_hit),
        .gcall_hit  (gcall_hit),
        .rd_req     (rd_req),
        .tx_data    (tx_data),
        .tx_wr      (tx_wr),
        .rx_ack     (rx_ack),
        .host_stop  (host_stop),
        .frame      (frame),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .irq_strobe (irq_strobe),
        .irq_code   (irq_code),
        .rx_data    (rx_data)
    );

endmodule

// File: tb/sim_i2c_coded_slave.sv
`timescale 1ns/1ps
module sim_i2c_coded_slave;

    localparam int HALF = 8;
    localparam logic [6:0] OWN = 7'h52;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [7:0] tx_data = '0;
    logic tx_wr = 1'b0, rx_ack = 1'b0, host_stop = 1'b0;
    logic scl_oe, sda_oe, irq_strobe;
    logic [3:0] irq_code;
    logic [7:0] rx_data;
    wire scl_bus = scl_m & ~scl_oe;
    wire sda_bus = sda_m & ~sda_oe;

    int n_chk = 0, n_err = 0;
    int irq_cnt = 0, run = 0, max_run = 0;
    logic [3:0] irq_last = '0;
    bit done = 0;

    always #2 clk = ~clk;

    i2c_coded_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN),
        .tx_data(tx_data), .tx_wr(tx_wr), .rx_ack(rx_ack), .host_stop(host_stop),
        .irq_strobe(irq_strobe), .irq_code(irq_code), .rx_data(rx_data)
    );

    always @(negedge clk) begin
        if (irq_strobe) begin
            irq_cnt  <= irq_cnt + 1;
            irq_last <= irq_code;
            run = run + 1;
            if (run > max_run) max_run = run;
        end else begin
            run = 0;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic scl_up();
        scl_m = 1'b1;
        while (!scl_bus) tick(1);
    endtask

    task automatic m_start();
        sda_m = 1'b1; tick(HALF);
        scl_up(); tick(HALF);
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b0; tick(HALF);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; tick(HALF);
        scl_up(); tick(HALF);
        sda_m = 1'b1; tick(HALF);
    endtask

    task automatic m_put(input logic b);
        sda_m = b; tick(HALF);
        scl_up(); tick(HALF);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic m_get(output logic b);
        sda_m = 1'b1; tick(HALF);
        scl_up(); tick(HALF / 2);
        b = sda_bus; tick(HALF / 2);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic m_byte_out(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) m_put(v[i]);
    endtask

    task automatic m_byte_in(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            m_get(b);
            v[i] = b;
        end
    endtask

    task automatic pulse_rx_ack();
        rx_ack = 1'b1; tick(1); rx_ack = 1'b0;
    endtask

    task automatic pulse_tx(input logic [7:0] v);
        tx_data = v; tx_wr = 1'b1; tick(1); tx_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 scl_oe after reset", scl_oe, 0);
        chk("R1 sda_oe after reset", sda_oe, 0);
        chk("R1 strobe after reset", irq_strobe, 0);
    endtask

    task automatic t_write_own();
        logic a; int c0;
        c0 = irq_cnt;
        m_start();
        m_byte_out({OWN, 1'b0});
        m_get(a);
        chk("R2 own write address ACK", a, 0);
        chk("R2 no event on write address", irq_cnt, c0);
        m_byte_out(8'hA5); tick(6);
        chk("R5 first byte event count", irq_cnt, c0 + 1);
        chk("R5 first byte code 0xC", irq_last, 4'hC);
        chk("R5 rx_data first byte", rx_data, 8'hA5);
        tick(20);
        chk("R5 SCL held until rx_ack", scl_oe, 1);
        pulse_rx_ack();
        m_get(a);
        chk("R5 byte ACK after service", a, 0);
        m_byte_out(8'h3C); tick(6);
        chk("R5 later byte code 0xE", irq_last, 4'hE);
        chk("R5 rx_data later byte", rx_data, 8'h3C);
        pulse_rx_ack();
        m_get(a);
        m_stop();
    endtask

    task automatic t_mismatch();
        logic a; int c0;
        c0 = irq_cnt;
        m_start();
        m_byte_out({7'h11, 1'b0});
        m_get(a);
        chk("R3 foreign address NACK", a, 1);
        m_byte_out(8'h00);
        m_get(a);
        chk("R3 data after foreign address NACK", a, 1);
        chk("R3 no event for foreign address", irq_cnt, c0);
        chk("R3 SCL not stretched", scl_oe, 0);
        m_stop();
    endtask

    task automatic t_gcall();
        logic a; int c0;
        c0 = irq_cnt;
        m_start();
        m_byte_out(8'h00); tick(6);
        chk("R4 general call event", irq_cnt, c0 + 1);
        chk("R4 general call code 0xF", irq_last, 4'hF);
        tick(10);
        chk("R4 SCL held until rx_ack", scl_oe, 1);
        pulse_rx_ack();
        m_get(a);
        chk("R4 general call ACK", a, 0);
        m_byte_out(8'h77); tick(6);
        chk("R4 first data after general call code 0xC", irq_last, 4'hC);
        chk("R4 general call data byte", rx_data, 8'h77);
        pulse_rx_ack();
        m_get(a);
        m_stop();
    endtask

    task automatic t_read();
        logic a; logic [7:0] v; int c0;
        m_start();
        m_byte_out({OWN, 1'b1});
        m_get(a);
        chk("R2 read address ACK", a, 0);
        tick(6);
        chk("R6 first transmit request 0xB", irq_last, 4'hB);
        tick(10);
        chk("R6 SCL held until tx_wr", scl_oe, 1);
        pulse_tx(8'hC9);
        m_byte_in(v);
        chk("R6 first byte MSB first", v, 8'hC9);
        m_put(1'b0); tick(6);
        chk("R6 later transmit request 0xD", irq_last, 4'hD);
        pulse_tx(8'h5A);
        m_byte_in(v);
        chk("R6 second byte", v, 8'h5A);
        m_put(1'b1);
        c0 = irq_cnt;
        m_byte_in(v);
        chk("R7 SDA released after NACK", v, 8'hFF);
        chk("R7 no event after NACK", irq_cnt, c0);
        m_stop();
    endtask

    task automatic t_restart();
        logic a; logic [7:0] v;
        m_start();
        m_byte_out({OWN, 1'b0});
        m_get(a);
        m_byte_out(8'h10); tick(6);
        chk("R8 code before restart", irq_last, 4'hC);
        pulse_rx_ack();
        m_get(a);
        m_start();
        m_byte_out({OWN, 1'b1});
        m_get(a);
        chk("R8 restart address ACK", a, 0);
        tick(6);
        chk("R8 restart re-arms first code 0xB", irq_last, 4'hB);
        pulse_tx(8'h81);
        m_byte_in(v);
        chk("R8 byte after restart", v, 8'h81);
        m_put(1'b1);
        m_stop();
    endtask

    task automatic t_host_stop();
        logic a; int c0;
        m_start();
        m_byte_out({OWN, 1'b0});
        m_get(a);
        m_byte_out(8'h44); tick(6);
        chk("R9 stretched before stop command", scl_oe, 1);
        host_stop = 1'b1; tick(1); host_stop = 1'b0;
        tick(1);
        chk("R9 SCL released by stop command", scl_oe, 0);
        chk("R9 SDA released by stop command", sda_oe, 0);
        c0 = irq_cnt;
        m_get(a);
        chk("R9 no ACK after stop command", a, 1);
        m_byte_out(8'h55);
        m_get(a);
        chk("R9 bus ignored after stop command", a, 1);
        chk("R9 no event after stop command", irq_cnt, c0);
        m_start();
        m_byte_out({OWN, 1'b0});
        m_get(a);
        chk("R9 responds after new START", a, 0);
        m_stop();
    endtask

    task automatic t_stop_vs_tx();
        logic a; logic [7:0] v; int c0;
        m_start();
        m_byte_out({OWN, 1'b1});
        m_get(a);
        tick(6);
        chk("R10 request pending before collision", irq_last, 4'hB);
        tx_data = 8'h00; tx_wr = 1'b1; host_stop = 1'b1;
        tick(1);
        tx_wr = 1'b0; host_stop = 1'b0;
        tick(1);
        chk("R10 SCL released", scl_oe, 0);
        chk("R10 SDA released", sda_oe, 0);
        c0 = irq_cnt;
        m_byte_in(v);
        chk("R10 loaded byte not driven", v, 8'hFF);
        m_put(1'b1);
        chk("R10 no event after stop", irq_cnt, c0);
        m_stop();
    endtask

    initial begin
        tick(5);
        t_reset();
        rst_n = 1'b1;
        tick(5);
        t_write_own();
        t_mismatch();
        t_gcall();
        t_read();
        t_restart();
        t_host_stop();
        t_stop_vs_tx();
        tick(4);
        chk("R11 strobe single cycle", max_run, 1);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

endmodule